// File: doc/BRIEF.md
# Program/Verify Address and Protection Unit

This block is the target-side address logic of a serial program/verify port for a 12-bit-word program memory. It holds the word address, advances it on increment strobes, and labels each address with the region it falls in: the configuration word, user program memory, customer ID words, or the reserved factory area. Every read request and every write request passes through the block before it reaches the storage array. The block applies the code-protection rules to read data and blocks writes that those rules forbid.

The configuration word is held inside the block. Its oscillator-select, watchdog-enable and reset-pin fields, and the derived protection state, are brought out as plain outputs. User and ID words live in an external array. The block gives that array an address, a write strobe and write data, and takes back combinational read data.

Reads return through a registered valid/data pair one cycle after the request. The port has no ready signal and applies no back-pressure: the consumer must take each read word in the cycle where `rd_valid` is high. Write requests complete in the cycle they are presented.

Top module: `pgm_addr_unit`

## Requirements
- R1: After reset, and on the clock edge that samples `enter_pulse` high, the address is 0xFFF and `space` is 0 (configuration word).
- R2: An `incr` sampled high changes the address on that same edge. From 0xFFF the address goes to 0x000 (`space` = 1, user memory). Elsewhere it goes up by one, except at the wrap points given in R3 and R4.
- R3: With `prog_mode` high, the address steps from 0x3FF to 0x400. Addresses 0x400–0x403 are ID words (`space` = 2). Addresses 0x404–0x43F are the factory area (`space` = 3). One increment past 0x43F returns the address to 0x000.
- R4: With `prog_mode` low, an increment at 0x3FF (or at any higher address) returns the address to 0x000, so the ID area is never reached by incrementing.
- R5: Once the address has left 0xFFF, no number of increments, including 4096, brings it back to 0xFFF. Only `enter_pulse` or reset does.
- R6: The configuration word resets to 0xFFF and is written and read at address 0xFFF. `cfg_osc` is bits 2–0, `cfg_wdt_en` is bit 3 and `cfg_rstpin` is bit 5.
- R7: `protect_on` is high exactly when configuration bits 11–6 and bit 4 are all 0. Any mix of values in these bits leaves protection off.
- R8: With protection on, a read at 0x040–0x3FE returns 0, and `rd_mask` is 0 while the address is in that range. Everywhere else `rd_mask` is all ones.
- R9: With protection on, writes to 0x040–0x3FE are dropped. Writes to 0x000–0x03F, 0x3FF, the ID words and the configuration word still take effect.
- R10: Reads in the factory area return 0xFFF, and writes there are dropped.
- R11: Write requests made while `prog_mode` is low are dropped, including writes to the configuration word.
- R12: A read request sampled on an edge raises `rd_valid` for the next cycle. `rd_data` then holds the word at the address that was current when the request was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_mode | input | 1 | High while the program/verify mode is active |
| enter_pulse | input | 1 | Mode-entry pulse; sets the address to the configuration word |
| incr | input | 1 | Increment-address strobe |
| rd_req | input | 1 | Read request for the current address |
| wr_req | input | 1 | Write request for the current address |
| wr_data | input | 12 | Word to write |
| mem_rdata | input | 12 | Combinational read data from the external array |
| addr | output | 12 | Current word address |
| space | output | 2 | Region: 0 config, 1 user, 2 ID, 3 factory |
| rd_mask | output | 12 | Mask applied to read data at the current address |
| rd_valid | output | 1 | Read data valid (one cycle after `rd_req`) |
| rd_data | output | 12 | Read word after the protection and region rules |
| mem_we | output | 1 | Write strobe to the external array |
| mem_wdata | output | 12 | Write data to the external array |
| protect_on | output | 1 | Code protection active |
| cfg_osc | output | 3 | Oscillator-select field of the configuration word |
| cfg_wdt_en | output | 1 | Watchdog-enable bit of the configuration word |
| cfg_rstpin | output | 1 | Reset-pin function bit of the configuration word |

## Verification
Several rules are checked by assertions on every clock edge:
- Entry and reset return the address to 0xFFF.
- Leaving 0xFFF always lands on 0x000, and increments never return to 0xFFF.
- Normal-mode increments stay inside user memory.
- No array write is issued outside program mode or into the protected range.
- Factory reads are all ones, and each read request yields a valid word one cycle later.

Other behaviour can only be shown by the bench's scenarios:
- Reading back the array after protected writes shows that the words are unchanged.
- Whole address walks show where each region begins and where the address wraps.
- Protection patterns with mixed bit values leave protection off.
- The configuration field outputs match the written word.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    SP_CFG  = 2'd0,
    SP_USER = 2'd1,
    SP_ID   = 2'd2,
    SP_FACT = 2'd3
  } space_e;

  localparam int OSC_LSB  = 0;
  localparam int OSC_W    = 3;
  localparam int WDT_BIT  = 3;
  localparam int RPIN_BIT = 5;
endpackage

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr #(
  parameter int AW           = 12,
  parameter int USER_LAST    = 'h3FF,
  parameter int SPECIAL_LAST = 'h43F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_mode,
  input  logic          enter_pulse,
  input  logic          incr,
  output logic [AW-1:0] pc_q
);
  localparam logic [AW-1:0] U_LAST = AW'(USER_LAST);
  localparam logic [AW-1:0] S_LAST = AW'(SPECIAL_LAST);
  localparam logic [AW-1:0] ONES   = '1;

  logic [AW-1:0] pc_nxt;

  // Next address: leaving the config word always lands on zero; each mode
  // has its own upper wrap point.
  always_comb begin
    if (pc_q == ONES)                          pc_nxt = '0;
    else if (!prog_mode && (pc_q >= U_LAST))   pc_nxt = '0;
    else if (pc_q >= S_LAST)                   pc_nxt = '0;
    else                                       pc_nxt = pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pc_q <= ONES;
    else if (enter_pulse) pc_q <= ONES;
    else if (incr)        pc_q <= pc_nxt;
  end

  // R1
  assert_entry_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |=> (pc_q == ONES));
  // R2
  assert_cfg_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && !enter_pulse && pc_q == ONES) |=> (pc_q == '0));
  // R4
  assert_normal_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && !enter_pulse && !prog_mode) |=> (pc_q <= U_LAST));
  // R5
  assert_cfg_unreach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && !enter_pulse) |=> (pc_q != ONES));
endmodule

// File: rtl/pgm_space_decode.sv
module pgm_space_decode
  import pgm_pkg::*;
#(
  parameter int AW        = 12,
  parameter int USER_LAST = 'h3FF,
  parameter int OPEN_LAST = 'h03F,
  parameter int ID_BASE   = 'h400,
  parameter int ID_COUNT  = 4
) (
  input  logic [AW-1:0] pc,
  output space_e        space,
  output logic          guard_zone
);
  localparam logic [AW-1:0] U_LAST  = AW'(USER_LAST);
  localparam logic [AW-1:0] O_LAST  = AW'(OPEN_LAST);
  localparam logic [AW-1:0] ID_LAST = AW'(ID_BASE + ID_COUNT - 1);
  localparam logic [AW-1:0] ONES    = '1;

  always_comb begin
    if (pc == ONES)          space = SP_CFG;
    else if (pc <= U_LAST)   space = SP_USER;
    else if (pc <= ID_LAST)  space = SP_ID;
    else                     space = SP_FACT;
  end

  // Protectable window: above the always-open low block, below the top word.
  assign guard_zone = (pc > O_LAST) && (pc < U_LAST);
endmodule

// File: rtl/pgm_cfg_store.sv
module pgm_cfg_store #(
  parameter int              DW      = 12,
  parameter logic [DW-1:0]   CP_MASK = 12'hFD0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cfg_q,
  output logic          protect_on
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '1;
    else if (wr_en) cfg_q <= wr_data;
  end

  assign protect_on = ((cfg_q & CP_MASK) == '0);

  // R6
  assert_cfg_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data)));
endmodule

// File: rtl/pgm_addr_unit.sv
module pgm_addr_unit
  import pgm_pkg::*;
#(
  parameter int AW           = 12,
  parameter int DW           = 12,
  parameter int USER_LAST    = 'h3FF,
  parameter int OPEN_LAST    = 'h03F,
  parameter int ID_BASE      = 'h400,
  parameter int ID_COUNT     = 4,
  parameter int SPECIAL_LAST = 'h43F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_mode,
  input  logic          enter_pulse,
  input  logic          incr,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] addr,
  output logic [1:0]    space,
  output logic [DW-1:0] rd_mask,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          protect_on,
  output logic [2:0]    cfg_osc,
  output logic          cfg_wdt_en,
  output logic          cfg_rstpin
);
  localparam logic [DW-1:0] CP_MASK = DW'(12'hFD0);

  logic [AW-1:0] pc;
  space_e        sp;
  logic          guard_zone;
  logic [DW-1:0] cfg_q;
  logic          wr_ok, cfg_we, blocked;
  logic [DW-1:0] rd_nxt;

  pgm_addr_ctr #(.AW(AW), .USER_LAST(USER_LAST), .SPECIAL_LAST(SPECIAL_LAST)) u_ctr (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .enter_pulse(enter_pulse), .incr(incr), .pc_q(pc));

  pgm_space_decode #(.AW(AW), .USER_LAST(USER_LAST), .OPEN_LAST(OPEN_LAST),
                     .ID_BASE(ID_BASE), .ID_COUNT(ID_COUNT)) u_dec (
    .pc(pc), .space(sp), .guard_zone(guard_zone));

  pgm_cfg_store #(.DW(DW), .CP_MASK(CP_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(wr_data),
    .cfg_q(cfg_q), .protect_on(protect_on));

  assign blocked = protect_on && guard_zone && (sp == SP_USER);
  assign wr_ok   = wr_req && prog_mode;
  assign cfg_we  = wr_ok && (sp == SP_CFG);
  assign mem_we  = wr_ok && (((sp == SP_USER) && !blocked) || (sp == SP_ID));
  assign mem_wdata = wr_data;
  assign rd_mask   = blocked ? '0 : '1;

  always_comb begin
    unique case (sp)
      SP_CFG:  rd_nxt = cfg_q;
      SP_FACT: rd_nxt = '1;
      default: rd_nxt = mem_rdata & rd_mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_nxt;
    end
  end

  assign addr       = pc;
  assign space      = sp;
  assign cfg_osc    = cfg_q[OSC_LSB +: OSC_W];
  assign cfg_wdt_en = cfg_q[WDT_BIT];
  assign cfg_rstpin = cfg_q[RPIN_BIT];

  // R9
  assert_no_protected_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(protect_on && guard_zone));
  // R11
  assert_write_needs_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || cfg_we) |-> prog_mode);
  // R10
  assert_factory_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sp == SP_FACT) |=> (rd_data == '1));
  // R12
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
endmodule

// File: tb/test_pgm_addr_unit.sv
module test_pgm_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_mode = 1'b1, enter_pulse = 1'b0, incr = 1'b0;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [11:0] wr_data = '0;
  logic [11:0] mem_rdata;
  logic [11:0] addr, rd_mask, rd_data, mem_wdata;
  logic [1:0]  space;
  logic        rd_valid, mem_we, protect_on, cfg_wdt_en, cfg_rstpin;
  logic [2:0]  cfg_osc;

  logic [11:0] mem [0:1087];
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pgm_addr_unit i_pgm_addr_unit (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .enter_pulse(enter_pulse),
    .incr(incr), .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .mem_rdata(mem_rdata), .addr(addr), .space(space), .rd_mask(rd_mask),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .protect_on(protect_on), .cfg_osc(cfg_osc), .cfg_wdt_en(cfg_wdt_en),
    .cfg_rstpin(cfg_rstpin));

  assign mem_rdata = (addr < 12'h440) ? mem[addr] : 12'h000;
  always @(posedge clk) if (mem_we) mem[addr] <= mem_wdata;

  function automatic logic [11:0] seed(int a);
    return 12'(a) ^ 12'hA5A;
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic enter();
    enter_pulse = 1'b1; @(negedge clk); enter_pulse = 1'b0;
  endtask
  task automatic step(int n);
    if (n > 0) begin
      incr = 1'b1; repeat (n) @(negedge clk); incr = 1'b0;
    end
  endtask
  task automatic write_w(logic [11:0] d);
    wr_req = 1'b1; wr_data = d; @(negedge clk); wr_req = 1'b0;
  endtask
  task automatic read_w(string tag, logic [11:0] exp);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    chk({tag, " valid"}, 12'(rd_valid), 12'h001);
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset addr", addr, 12'hFFF);
    chk("R1 reset space", 12'(space), 12'h000);
    chk("R6 reset osc", 12'(cfg_osc), 12'h007);
    chk("R7 reset protect", 12'(protect_on), 12'h000);
  endtask

  task automatic t_cfg();
    prog_mode = 1'b1; enter();
    write_w(12'h123);
    read_w("R6 cfg readback", 12'h123);
    chk("R6 osc field", 12'(cfg_osc), 12'h003);
    chk("R6 wdt field", 12'(cfg_wdt_en), 12'h000);
    chk("R6 rstpin field", 12'(cfg_rstpin), 12'h001);
    chk("R7 mixed bits off", 12'(protect_on), 12'h000);
    write_w(12'h000);
    chk("R7 all zero on", 12'(protect_on), 12'h001);
    write_w(12'h010);
    chk("R7 bit4 only off", 12'(protect_on), 12'h000);
    write_w(12'hFFF);
  endtask

  task automatic t_walk();
    prog_mode = 1'b1; enter();
    chk("R1 entry addr", addr, 12'hFFF);
    step(1);
    chk("R2 wrap to zero", addr, 12'h000);
    chk("R2 user space", 12'(space), 12'h001);
    step(1);
    chk("R2 plus one", addr, 12'h001);
    step(1022);
    chk("R3 last user", addr, 12'h3FF);
    step(1);
    chk("R3 into id", addr, 12'h400);
    chk("R3 id space", 12'(space), 12'h002);
    write_w(12'h00D);
    read_w("R3 id rw", 12'h00D);
    step(4);
    chk("R3 factory space", 12'(space), 12'h003);
    read_w("R10 factory ones", 12'hFFF);
    write_w(12'h000);
    read_w("R10 factory write dropped", 12'hFFF);
    step(59);
    chk("R3 special end", addr, 12'h43F);
    step(1);
    chk("R3 wrap after special", addr, 12'h000);
  endtask

  task automatic t_wrap4096();
    int bad = 0;
    prog_mode = 1'b1; enter();
    incr = 1'b1;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      if (addr == 12'hFFF || space == 2'd0) bad++;
    end
    incr = 1'b0;
    chk("R5 cfg never revisited", 12'(bad), 12'h000);
  endtask

  task automatic t_protect();
    prog_mode = 1'b1; enter();
    write_w(12'h02F);
    chk("R7 protect on", 12'(protect_on), 12'h001);
    step(64);
    write_w(12'h111);
    read_w("R9 low block writable", 12'h111);
    step(1);
    chk("R8 mask zero", rd_mask, 12'h000);
    read_w("R8 protected read zero", 12'h000);
    write_w(12'h777);
    step(12'h3BE);
    read_w("R8 top of window zero", 12'h000);
    step(1);
    chk("R8 mask ones at top", rd_mask, 12'hFFF);
    write_w(12'h0C5);
    read_w("R9 top word writable", 12'h0C5);
    step(1);
    write_w(12'h003);
    read_w("R9 id writable", 12'h003);
    enter();
    write_w(12'h040);
    chk("R7 bit6 only off", 12'(protect_on), 12'h000);
    step(65);
    read_w("R9 protected write dropped", seed(12'h040));
  endtask

  task automatic t_normal();
    prog_mode = 1'b0; enter();
    write_w(12'h000);
    read_w("R11 cfg write dropped", 12'h040);
    step(6);
    write_w(12'h999);
    read_w("R11 user write dropped", seed(5));
    step(12'h3FA);
    chk("R4 last user", addr, 12'h3FF);
    step(1);
    chk("R4 wrap to zero", addr, 12'h000);
    rd_req = 1'b1; @(negedge clk);
    rd_req = 1'b0; @(negedge clk);
    chk("R12 valid one cycle", 12'(rd_valid), 12'h000);
  endtask

  initial begin
    for (int i = 0; i < 1088; i++) mem[i] = seed(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_walk();
    t_wrap4096();
    t_protect();
    t_normal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule